// File: doc/BRIEF.md
# Byte/Word ALU with Status and Control Flags

This block is the arithmetic core of a small 8/16-bit integer datapath. Each cycle it takes two operands, an operation code and a width select, and produces a result combinationally. The operation set is add, subtract, AND, OR, XOR, increment, one's complement and a single-bit left shift. With the width select low, only the low byte of each operand is used and the upper result byte reads zero.

Alongside the result the block builds six status indications: carry, zero, sign, parity, overflow and auxiliary carry. These are captured into a flag register on the clock edge when the flag-write enable is high. The same register also holds three control bits: string direction, interrupt enable and single-step trap. A separate write enable loads these three bits directly, and that load never disturbs the status bits.

Top module: `byteword_alu`

## Requirements
- R1: `op_i` selects 0=add, 1=subtract (a-b), 2=AND, 3=OR, 4=XOR, 5=increment a, 6=one's complement of a, 7=shift a left by one with a zero filled in. `word_i`=1 gives a 16-bit operation. `word_i`=0 gives an 8-bit operation on the low operand bytes, with `result_o[15:8]` forced to zero.
- R2: The carry flag (`flags_o[0]`) is set on a carry out of the top bit of the selected width for add, and on a borrow (a < b unsigned) for subtract.
- R3: The zero flag (`flags_o[3]`) is set when the result at the selected width is all zeros. The sign flag (`flags_o[4]`) equals the top bit of the result at the selected width.
- R4: The parity flag (`flags_o[1]`) is set when `result_o[7:0]` holds an even number of ones, for both widths.
- R5: The overflow flag (`flags_o[5]`) is set when the signed add, subtract or increment result lies outside the two's-complement range of the selected width.
- R6: The auxiliary-carry flag (`flags_o[2]`) is set on a carry out of bit 3 for add and increment, and on a borrow into bit 3 for subtract, for both widths.
- R7: AND, OR, XOR and complement clear carry, overflow and auxiliary carry.
- R8: Increment leaves the carry flag at its previous value.
- R9: A left shift loads the bit shifted out into carry. It sets overflow when the sign bit changes, and it clears auxiliary carry.
- R10: Status flags change only on a rising clock edge with `flag_we_i`=1. With both write enables low, the whole flag word holds.
- R11: On a rising edge with `ctl_we_i`=1, `ctl_i[0]`, `ctl_i[1]` and `ctl_i[2]` are loaded into direction `flags_o[6]`, interrupt-enable `flags_o[7]` and trap `flags_o[8]`. This happens whatever the value of `flag_we_i`, and a status write leaves these bits unchanged.
- R12: Asserting `rst_ni` low clears every flag bit asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flag_we_i | input | 1 | Capture status flags from the current operation |
| ctl_we_i | input | 1 | Load the control flags from ctl_i |
| ctl_i | input | 3 | New values for direction, interrupt enable and trap |
| result_o | output | 16 | Operation result, zero-extended in byte mode |
| flags_o | output | 9 | Flag word: C, P, A, Z, S, O, D, I, T from bit 0 upward |

## Verification
Byte mode is swept over all 256 values of the first operand against a set of second operands that includes 0x7F, 0x80, 0xFF and nibble boundaries, for every operation. Garbage is placed in the upper operand bytes, so leakage of those bytes shows up in the result or the flags. Word mode runs mixed random operation sequences together with corner words such as 0x7FFF, 0x8000 and 0xFFFF. These tell the byte and word carry, overflow and sign positions apart, and make increment's carry hold depend on whatever the previous operation left. Separate directed steps cover the worked word addition, flag hold with the enables low, control loads mixed with status writes, and reset mid-run.

// File: rtl/byteword_alu_pkg.sv
package byteword_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_INC = 3'd5,
    OP_NOT = 3'd6,
    OP_SHL = 3'd7
  } alu_op_e;

  localparam int F_C = 0;
  localparam int F_P = 1;
  localparam int F_A = 2;
  localparam int F_Z = 3;
  localparam int F_S = 4;
  localparam int F_O = 5;
  localparam int F_D = 6;
  localparam int F_I = 7;
  localparam int F_T = 8;
  localparam int NF  = 9;
  localparam int NCTL = 3;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } status_t;
endpackage

// File: rtl/alu_lane.sv
module alu_lane
  import byteword_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           cry_old_i,
  output logic [W-1:0]   res_o,
  output logic           cry_o,
  output logic           ovf_o,
  output logic           aux_o
);
  localparam int MSB = W - 1;

  logic [W:0] wide;
  logic [4:0] nib;

  always_comb begin
    wide  = '0;
    nib   = '0;
    res_o = '0;
    cry_o = 1'b0;
    ovf_o = 1'b0;
    aux_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        wide  = {1'b0, a_i} + {1'b0, b_i};
        nib   = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]};
        res_o = wide[W-1:0];
        cry_o = wide[W];
        aux_o = nib[4];
        ovf_o = (a_i[MSB] == b_i[MSB]) && (wide[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        wide  = {1'b0, a_i} - {1'b0, b_i};
        nib   = {1'b0, a_i[3:0]} - {1'b0, b_i[3:0]};
        res_o = wide[W-1:0];
        cry_o = wide[W];
        aux_o = nib[4];
        ovf_o = (a_i[MSB] != b_i[MSB]) && (wide[MSB] != a_i[MSB]);
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_INC: begin
        wide  = {1'b0, a_i} + {{W{1'b0}}, 1'b1};
        nib   = {1'b0, a_i[3:0]} + 5'd1;
        res_o = wide[W-1:0];
        cry_o = cry_old_i;
        aux_o = nib[4];
        ovf_o = !a_i[MSB] && wide[MSB];
      end
      OP_NOT: res_o = ~a_i;
      OP_SHL: begin
        res_o = {a_i[W-2:0], 1'b0};
        cry_o = a_i[MSB];
        ovf_o = a_i[MSB] ^ a_i[MSB-1];
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status
  import byteword_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          word_i,
  input  logic [DW-1:0] res_i,
  input  logic          cry_i,
  input  logic          ovf_i,
  input  logic          aux_i,
  output status_t       st_o
);
  logic [DW-1:0] mask;

  assign mask = word_i ? {DW{1'b1}} : {{(DW-BW){1'b0}}, {BW{1'b1}}};

  always_comb begin
    st_o.cry = cry_i;
    st_o.ovf = ovf_i;
    st_o.aux = aux_i;
    st_o.zer = ((res_i & mask) == '0);
    st_o.sgn = word_i ? res_i[DW-1] : res_i[BW-1];
    st_o.par = ~^res_i[7:0];  // low byte only, any width
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import byteword_alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            st_we_i,
  input  status_t         st_i,
  input  logic            ctl_we_i,
  input  logic [NCTL-1:0] ctl_i,
  output logic [NF-1:0]   flags_o
);
  status_t         st_q;
  logic [NCTL-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (st_we_i) begin
      st_q <= st_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q <= ctl_i;
    end
  end

  always_comb begin
    flags_o      = '0;
    flags_o[F_C] = st_q.cry;
    flags_o[F_P] = st_q.par;
    flags_o[F_A] = st_q.aux;
    flags_o[F_Z] = st_q.zer;
    flags_o[F_S] = st_q.sgn;
    flags_o[F_O] = st_q.ovf;
    flags_o[F_D] = ctl_q[0];
    flags_o[F_I] = ctl_q[1];
    flags_o[F_T] = ctl_q[2];
  end
endmodule

// File: rtl/byteword_alu.sv
module byteword_alu
  import byteword_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      op_i,
  input  logic            word_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            flag_we_i,
  input  logic            ctl_we_i,
  input  logic [NCTL-1:0] ctl_i,
  output logic [DW-1:0]   result_o,
  output logic [NF-1:0]   flags_o
);
  localparam int NLANE = 2;  // lane 0 byte, lane 1 word

  alu_op_e       op;
  logic [DW-1:0] lane_res [NLANE];
  logic          lane_cry [NLANE];
  logic          lane_ovf [NLANE];
  logic          lane_aux [NLANE];
  status_t       st;

  assign op = alu_op_e'(op_i);

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    localparam int LW = (gi == 0) ? BW : DW;
    logic [LW-1:0] r;

    alu_lane #(.W(LW)) u_lane (
      .op_i      (op),
      .a_i       (a_i[LW-1:0]),
      .b_i       (b_i[LW-1:0]),
      .cry_old_i (flags_o[F_C]),
      .res_o     (r),
      .cry_o     (lane_cry[gi]),
      .ovf_o     (lane_ovf[gi]),
      .aux_o     (lane_aux[gi])
    );

    if (LW < DW) begin : g_ext
      assign lane_res[gi] = {{(DW-LW){1'b0}}, r};
    end else begin : g_full
      assign lane_res[gi] = r;
    end
  end

  assign result_o = word_i ? lane_res[1] : lane_res[0];

  alu_status #(.DW(DW), .BW(BW)) u_status (
    .word_i (word_i),
    .res_i  (result_o),
    .cry_i  (word_i ? lane_cry[1] : lane_cry[0]),
    .ovf_i  (word_i ? lane_ovf[1] : lane_ovf[0]),
    .aux_i  (word_i ? lane_aux[1] : lane_aux[0]),
    .st_o   (st)
  );

  flag_reg u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_we_i  (flag_we_i),
    .st_i     (st),
    .ctl_we_i (ctl_we_i),
    .ctl_i    (ctl_i),
    .flags_o  (flags_o)
  );
endmodule

// File: rtl/byteword_alu_chk.sv
module byteword_alu_chk
  import byteword_alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      op_i,
  input logic            word_i,
  input logic            flag_we_i,
  input logic            ctl_we_i,
  input logic [NCTL-1:0] ctl_i,
  input logic [DW-1:0]   result_o,
  input logic [NF-1:0]   flags_o
);
  always_comb begin
    if (rst_ni && !word_i) begin
      AST_BYTE_UPPER: assert (result_o[DW-1:BW] == '0);  // R1
    end
  end

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[F_Z] == ($past(result_o) == '0));  // R3

  AST_SIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[F_S] == $past(word_i ? result_o[DW-1] : result_o[BW-1]));  // R3

  AST_PARITY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[F_P] == ~^$past(result_o[7:0]));  // R4

  AST_LOGIC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i inside {3'd2, 3'd3, 3'd4, 3'd6}))
    |=> !flags_o[F_C] && !flags_o[F_O] && !flags_o[F_A]);  // R7

  AST_INC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == 3'd5) |=> $stable(flags_o[F_C]));  // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && !ctl_we_i) |=> $stable(flags_o));  // R10

  AST_CTL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> flags_o[F_T:F_D] == $past(ctl_i));  // R11

  AST_CTL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(flags_o[F_T:F_D]));  // R11
endmodule

bind byteword_alu byteword_alu_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .word_i    (word_i),
  .flag_we_i (flag_we_i),
  .ctl_we_i  (ctl_we_i),
  .ctl_i     (ctl_i),
  .result_o  (result_o),
  .flags_o   (flags_o)
);

// File: tb/byteword_alu_tb.sv
module byteword_alu_tb;
  localparam int DW = 16;
  localparam int BW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic        word = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        flag_we = 1'b0, ctl_we = 1'b0;
  logic [2:0]  ctl = '0;
  logic [15:0] result;
  logic [8:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_flags = '0;
  logic [15:0] exp_res;
  int unsigned seed = 32'h1234_5678;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byteword_alu #(.DW(DW), .BW(BW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .op_i (op), .word_i (word),
    .a_i (a), .b_i (b), .flag_we_i (flag_we), .ctl_we_i (ctl_we),
    .ctl_i (ctl), .result_o (result), .flags_o (flags)
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic int sval(int v, int n);
    return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
  endfunction

  // Reference model: sets exp_res and the status part of exp_flags
  task automatic model(input int o, input bit w, input int av, input int bv);
    int n, m, ua, ub, r, sa, sb, sr;
    bit c, v, ac;
    n  = w ? 16 : 8;
    m  = (1 << n) - 1;
    ua = av & m;
    ub = bv & m;
    sa = sval(ua, n);
    sb = sval(ub, n);
    c  = 1'b0; v = 1'b0; ac = 1'b0; r = 0;
    case (o)
      0: begin r = ua + ub; c = (r >> n) & 1; ac = ((ua & 15) + (ub & 15)) > 15;
               sr = sa + sb; v = (sr > m / 2) || (sr < -(m / 2) - 1); end
      1: begin r = ua - ub; c = ua < ub; ac = (ua & 15) < (ub & 15);
               sr = sa - sb; v = (sr > m / 2) || (sr < -(m / 2) - 1); end
      2: r = ua & ub;
      3: r = ua | ub;
      4: r = ua ^ ub;
      5: begin r = ua + 1; c = exp_flags[0]; ac = (ua & 15) == 15; v = (ua == m / 2); end
      6: r = ~ua;
      default: begin r = ua << 1; c = (ua >> (n - 1)) & 1; v = c ^ ((r >> (n - 1)) & 1); end
    endcase
    r = r & m;
    exp_res = 16'(r);
    exp_flags[0] = c;
    exp_flags[1] = ~^exp_res[7:0];
    exp_flags[2] = ac;
    exp_flags[3] = (r == 0);
    exp_flags[4] = (r >> (n - 1)) & 1;
    exp_flags[5] = v;
  endtask

  function automatic string op_tag(int o);
    case (o)
      0, 1: return "R2/R5/R6";
      5: return "R8";
      7: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check_flags(input string ctx);
    string nm [9] = '{"R2 carry", "R4 parity", "R6 aux", "R3 zero", "R3 sign",
                      "R5 overflow", "R11 dir", "R11 ien", "R11 trap"};
    checks++;
    if (flags !== exp_flags) begin
      errors++;
      for (int i = 0; i < 9; i++)
        if (flags[i] !== exp_flags[i])
          $display("FAIL %s %s: got %b expected %b", ctx, nm[i], flags[i], exp_flags[i]);
    end
  endtask

  // one operation: drive at negedge, check result, check flags after edge
  task automatic run_op(input int o, input bit w, input logic [15:0] av,
                        input logic [15:0] bv, input bit we);
    @(negedge clk);
    op = 3'(o); word = w; a = av; b = bv; flag_we = we; ctl_we = 1'b0;
    #1;
    if (we) model(o, w, av, bv);
    else begin
      logic [8:0] keep = exp_flags;
      model(o, w, av, bv);
      exp_flags = keep;
    end
    checks++;
    if (result !== exp_res) begin
      errors++;
      $display("FAIL R1 op=%0d w=%0b a=%h b=%h: result got %h expected %h",
               o, w, av, bv, result, exp_res);
    end
    @(posedge clk); #1;
    check_flags($sformatf("%s op=%0d w=%0b a=%h b=%h", we ? op_tag(o) : "R10", o, w, av, bv));
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] bl [19];
    logic [15:0] wc [8];
    for (int k = 0; k < 16; k++) bl[k] = 16'(k * 17);
    bl[16] = 16'h007F; bl[17] = 16'h0080; bl[18] = 16'h0001;
    wc = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0FFF, 16'h00FF, 16'h8001};

    repeat (3) @(posedge clk);
    #1;
    exp_flags = '0;
    check_flags("R12 after reset");
    @(negedge clk) rst_n = 1'b1;

    // worked word addition
    run_op(0, 1'b1, 16'h65D1, 16'h2359, 1'b1);
    checks++;
    if (flags[5:0] !== 6'b110000) begin
      errors++;
      $display("FAIL R5 worked sum flags got %b expected %b", flags[5:0], 6'b110000);
    end

    // control loads, mixed with status writes (R11)
    @(negedge clk); ctl = 3'b101; ctl_we = 1'b1; flag_we = 1'b0;
    @(posedge clk); #1; exp_flags[8:6] = 3'b101;
    check_flags("R11 ctl load");
    @(negedge clk); ctl_we = 1'b0; ctl = 3'b010;
    run_op(1, 1'b0, 16'h0000, 16'h0001, 1'b1);  // status write, ctl must stay
    @(negedge clk);
    op = 3'd0; word = 1'b1; a = 16'hFFFF; b = 16'h0001; flag_we = 1'b1;
    ctl = 3'b010; ctl_we = 1'b1;
    #1; model(0, 1'b1, 16'hFFFF, 16'h0001);
    @(posedge clk); #1; exp_flags[8:6] = 3'b010;
    check_flags("R11 ctl with status write");
    @(negedge clk); ctl_we = 1'b0;

    // hold with flag write low (R10)
    run_op(4, 1'b1, 16'h00FF, 16'h00FF, 1'b0);
    run_op(7, 1'b0, 16'h0080, 16'h0000, 1'b0);

    // byte sweep with garbage in upper operand bytes
    for (int o = 0; o < 8; o++)
      for (int av = 0; av < 256; av++)
        for (int k = 0; k < 19; k++)
          run_op(o, 1'b0, {8'(rnd()), 8'(av)}, {8'(rnd()), bl[k][7:0]}, 1'b1);

    // word corners, all ops
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(o, 1'b1, wc[i], wc[j], 1'b1);

    // mixed random sequence, both widths
    for (int i = 0; i < 20000; i++)
      run_op(int'(rnd() % 8), 1'(rnd()), 16'(rnd()), 16'(rnd()), 1'(rnd() % 4 != 0));

    // reset mid-run (R12)
    @(negedge clk); ctl = 3'b111; ctl_we = 1'b1; flag_we = 1'b1;
    @(negedge clk); rst_n = 1'b0; ctl_we = 1'b0; flag_we = 1'b0;
    #1; exp_flags = '0;
    check_flags("R12 mid-run reset");
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule